// File: doc/BRIEF.md
# Configurable PAL Output Macrocell

This block is one output cell of a small sum-of-products logic device. It receives the already-formed OR sum of its product terms. A 2-bit mode field then decides two things. The first is whether that sum reaches the pin through a flip-flop or directly. The second is whether the pin level is the sum itself or its complement. The mode field drives a four-way output multiplexer.

A second, one-bit selector decides what goes back into the AND array. It can be the cell's own internal signal, or the level present on the external pin. The internal signal is the register output in the registered modes and the raw sum in the combinational modes. In both cases it is taken before polarity is applied.

The pin is modelled as a data value plus a separate enable. The pin level can still be read back through the feedback path while the driver is off. There is no handshake on any port. Every input is a static configuration bit or a level sampled each clock.

Top module: `pal_out_cell`

## Requirements
- R1: With mode 2'b00 (registered, active-low), `pin_drv` equals the inverse of the `sop_in` value captured at the most recent rising clock edge.
- R2: With mode 2'b01 (registered, active-high), `pin_drv` equals the `sop_in` value captured at the most recent rising clock edge.
- R3: With mode 2'b10 (combinational, active-low), `pin_drv` equals the inverse of the present `sop_in` within the same cycle.
- R4: With mode 2'b11 (combinational, active-high), `pin_drv` equals the present `sop_in` within the same cycle.
- R5: A rising edge with `rst` high clears the register to 0, whatever the value of `sop_in`. In mode 2'b01 this makes `pin_drv` 0 in the following cycle.
- R6: `pin_oe` follows `oe`, and `pin_drv` keeps its mode-defined value when `oe` is low. With `oe` low, `pin_in` still reaches `fb_out` when `fb_pin` is 1.
- R7: With `fb_pin` = 1, `fb_out` equals `pin_in` in every mode.
- R8: With `fb_pin` = 0 and a registered mode (mode bit 1 = 0), `fb_out` equals the register value, with no polarity inversion applied.
- R9: With `fb_pin` = 0 and a combinational mode (mode bit 1 = 1), `fb_out` equals the present `sop_in`, with no polarity inversion applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the cell register |
| rst | input | 1 | Synchronous reset, active high; clears the register |
| sop_in | input | 1 | OR sum of the cell's product terms |
| oe | input | 1 | Output enable for the pin driver |
| mode | input | 2 | Bit 1: 1 = combinational, 0 = registered; bit 0: 1 = active-high, 0 = active-low |
| fb_pin | input | 1 | Feedback source: 1 = external pin, 0 = internal signal |
| pin_in | input | 1 | Level read from the external pin |
| pin_drv | output | 1 | Value driven onto the pin when enabled |
| pin_oe | output | 1 | Pin driver enable; low means the pin floats |
| fb_out | output | 1 | Signal returned to the AND array |

## Verification
The registered-mode properties compare against the value of `sop_in` one edge earlier. They therefore assume that `sop_in` and `mode` are stable around each rising edge, and they stay silent on the first edge after reset is released. The stimulus changes every input a few nanoseconds after a rising edge and samples outputs well before the next edge, so each mode is entered with a settled register. The sweep covers all 128 combinations of mode, feedback source, enable, pin level and the previous and present sums. A separate reset step applies `rst` with `sop_in` held at 1.

// File: rtl/pal_cell_pkg.sv
package pal_cell_pkg;
  localparam int MODE_W = 2;
  typedef enum logic [MODE_W-1:0] {
    CELL_REG_LO  = 2'b00,
    CELL_REG_HI  = 2'b01,
    CELL_COMB_LO = 2'b10,
    CELL_COMB_HI = 2'b11
  } cell_mode_e;

  function automatic logic is_comb(input cell_mode_e m);
    return m[1];
  endfunction

  function automatic logic is_active_high(input cell_mode_e m);
    return m[0];
  endfunction
endpackage

// File: rtl/pal_cell_reg.sv
module pal_cell_reg #(
  parameter logic PRELOAD = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= PRELOAD;
    else     q <= d;
  end
endmodule

// File: rtl/pal_cell_outmux.sv
module pal_cell_outmux
  import pal_cell_pkg::*;
(
  input  cell_mode_e mode,
  input  logic       q,
  input  logic       sop,
  output logic       drive
);
  // four-way selector steered by the mode bits; polarity after source choice
  always_comb begin
    unique case (mode)
      CELL_REG_LO:  drive = ~q;
      CELL_REG_HI:  drive =  q;
      CELL_COMB_LO: drive = ~sop;
      CELL_COMB_HI: drive =  sop;
      default:      drive = 1'b0;
    endcase
  end
endmodule

// File: rtl/pal_cell_fbmux.sv
module pal_cell_fbmux (
  input  logic use_pin,
  input  logic internal,
  input  logic pin,
  output logic fb
);
  always_comb fb = use_pin ? pin : internal;
endmodule

// File: rtl/pal_out_cell.sv
module pal_out_cell
  import pal_cell_pkg::*;
#(
  parameter logic PRELOAD = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sop_in,
  input  logic        oe,
  input  logic [1:0]  mode,
  input  logic        fb_pin,
  input  logic        pin_in,
  output logic        pin_drv,
  output logic        pin_oe,
  output logic        fb_out
);
  cell_mode_e mode_e;
  logic       q;
  logic       internal_fb;

  assign mode_e = cell_mode_e'(mode);

  pal_cell_reg #(.PRELOAD(PRELOAD)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (sop_in),
    .q   (q)
  );

  pal_cell_outmux u_outmux (
    .mode  (mode_e),
    .q     (q),
    .sop   (sop_in),
    .drive (pin_drv)
  );

  // internal feedback is taken ahead of the polarity stage
  assign internal_fb = is_comb(mode_e) ? sop_in : q;

  pal_cell_fbmux u_fbmux (
    .use_pin  (fb_pin),
    .internal (internal_fb),
    .pin      (pin_in),
    .fb       (fb_out)
  );

  assign pin_oe = oe;

  a_r1_reg_low: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) && !$past(rst) |-> pin_drv == !$past(sop_in));

  a_r2_reg_high: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) && !$past(rst) |-> pin_drv == $past(sop_in));

  a_r3_comb_low: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |-> pin_drv == !sop_in);

  a_r4_comb_high: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |-> pin_drv == sop_in);

  a_r5_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && (mode == 2'b01) |-> pin_drv == PRELOAD);

  a_r7_pin_feedback: assert property (@(posedge clk) disable iff (rst)
    fb_pin |-> fb_out == pin_in);

  a_r8_reg_feedback: assert property (@(posedge clk) disable iff (rst)
    !fb_pin && !mode[1] && !$past(rst) |-> fb_out == $past(sop_in));

  a_r9_comb_feedback: assert property (@(posedge clk) disable iff (rst)
    !fb_pin && mode[1] |-> fb_out == sop_in);
endmodule

// File: tb/test_pal_out_cell.sv
module test_pal_out_cell;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sop_in = 1'b0;
  logic oe = 1'b0;
  logic [1:0] mode = 2'b01;
  logic fb_pin = 1'b0;
  logic pin_in = 1'b0;
  logic pin_drv, pin_oe, fb_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pal_out_cell i_pal_out_cell (
    .clk     (clk),
    .rst     (rst),
    .sop_in  (sop_in),
    .oe      (oe),
    .mode    (mode),
    .fb_pin  (fb_pin),
    .pin_in  (pin_in),
    .pin_drv (pin_drv),
    .pin_oe  (pin_oe),
    .fb_out  (fb_out)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  initial begin
    // reset state: register cleared even with sop_in high (R5)
    sop_in = 1'b1;
    @(posedge clk); @(posedge clk);
    #3;
    check("R5", "pin_drv in reset", pin_drv, 1'b0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #3;
    check("R2", "capture after reset", pin_drv, 1'b1);
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #3;
    check("R5", "clear with sop high", pin_drv, 1'b0);
    check("R8", "feedback after clear", fb_out, 1'b0);
    @(negedge clk) rst = 1'b0;

    // exhaustive sweep
    for (int k = 0; k < 128; k++) begin
      logic a, b, p, e, f, hi, comb;
      logic exp_drv, exp_fb;
      string rq;
      a    = k[0];
      b    = k[1];
      p    = k[2];
      e    = k[3];
      f    = k[4];
      hi   = k[5];
      comb = k[6];
      @(negedge clk) sop_in = a;
      @(posedge clk);
      #2;
      sop_in = b; mode = {comb, hi}; oe = e; fb_pin = f; pin_in = p;
      #5;
      exp_drv = comb ? (hi ? b : !b) : (hi ? a : !a);
      rq = comb ? (hi ? "R4" : "R3") : (hi ? "R2" : "R1");
      check(rq, "pin_drv", pin_drv, exp_drv);
      check("R6", "pin_oe", pin_oe, e);
      exp_fb = f ? p : (comb ? b : a);
      rq = f ? (e ? "R7" : "R6") : (comb ? "R9" : "R8");
      check(rq, "fb_out", fb_out, exp_fb);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule